// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Controller

This block moves single bytes or 16-bit words between peripheral registers and a data RAM. It has a parameterized number of channels, from 1 to 15. Each channel copies in one direction only, so reading from and writing to the same peripheral takes two channels. Every channel has its own settings: direction, element size, RAM addressing mode, block mode, an 8-bit request source code, two RAM start addresses, a peripheral address and a block length. The block length is stored as the element count minus one.

A channel is armed by a one-cycle pulse on its arm input. Arming enables the channel, points it at start address A and clears its progress. After that, each pulse on the selected request line, or on the channel's software force input, asks for one element transfer. A fixed-priority arbiter serves one element at a time, and the lowest channel number wins. Because arbitration happens per element, a higher-priority channel can be served between two elements of a lower channel's block.

Each element takes two bus operations on a single master bus with a valid/ready handshake: a read from the source, then a write to the destination. At the end of a block the channel pulses its full-block interrupt. What happens next depends on the block mode:
- one-shot: the channel disables itself.
- auto-repeat: the channel returns to start address A.
- ping-pong: the channel switches to the other start address.

Top module: `dmax_top`

## Requirements
- R1: Out of reset, every channel is disabled, `bus_valid` is 0, and every interrupt output is 0.
- R2: Direction bit 0 reads `cfg_per_addr` with `bus_to_ram`=0, then writes the RAM address with `bus_to_ram`=1. Direction bit 1 does the reverse: it reads RAM and writes the peripheral.
- R3: When several channels are pending, the lowest-numbered channel is served first. Arbitration is repeated after every element.
- R4: The 2-bit addressing mode selects the RAM address behaviour. Code 0 advances the address after each element, by 1 for bytes and by 2 for words. Code 1 keeps the address fixed.
- R5: Addressing mode code 2 uses the active start address plus the offset that the peripheral presents on `src_off` together with its request.
- R6: With the byte bit set, `bus_byte` is 1 and the written data is the low 8 bits of the read data, zero-extended.
- R7: The 8-bit select code picks request line `src_req[code]`. A code of `NSRC` or more selects no line. A `sw_force` pulse also requests one element.
- R8: Block mode code 0 (one-shot): after element `cfg_len` the channel pulses `irq_full` for one cycle and becomes disabled.
- R9: Block mode code 1 (auto-repeat): after a block the channel restarts at address A and stays enabled.
- R10: Block mode code 2 (ping-pong): each completed block switches the start address between A and B, beginning with A. The channel stays enabled.
- R11: With the half-interrupt bit set, `irq_half` pulses once per block, after element index floor(N/2) has been written, where N is `cfg_len`+1.
- R12: A request to a disabled channel is ignored. Several requests that arrive while a channel is already pending merge into one element transfer.
- R13: While `bus_valid` is high and `bus_ready` is low, the bus address, write flag and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_arm | input | NCH | Per-channel pulse: enable and restart at address A |
| cfg_dir | input | NCH | Direction, 1 = RAM to peripheral |
| cfg_byte | input | NCH | 1 = byte elements, 0 = word elements |
| cfg_amode | input | 2*NCH | RAM addressing mode per channel |
| cfg_omode | input | 2*NCH | Block mode per channel |
| cfg_half_en | input | NCH | Enable the half-block interrupt |
| cfg_srcsel | input | 8*NCH | Request source code per channel |
| cfg_ram_a | input | AW*NCH | RAM start address A |
| cfg_ram_b | input | AW*NCH | RAM start address B (ping-pong) |
| cfg_per_addr | input | AW*NCH | Peripheral register address |
| cfg_len | input | CW*NCH | Elements per block minus one |
| sw_force | input | NCH | Software request pulse |
| src_req | input | NSRC | Request pulses from the sources |
| src_off | input | OW*NSRC | Per-source RAM offset for addressing mode 2 |
| bus_valid | output | 1 | Bus operation pending |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_to_ram | output | 1 | 1 = RAM space, 0 = peripheral space |
| bus_byte | output | 1 | Byte-sized operation |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Operation completes at this edge |
| bus_rdata | input | DW | Read data, valid with bus_ready |
| ch_enabled | output | NCH | Channel enabled state |
| irq_half | output | NCH | Half-block interrupt pulse |
| irq_full | output | NCH | Full-block interrupt pulse |

## Verification
The properties assume three things about the inputs:
- A channel's settings stay unchanged while the channel is enabled.
- A channel is never re-armed while one of its own elements is on the bus.
- `bus_rdata` is valid in the cycle where `bus_ready` is high.

The stimulus respects all three. It reconfigures only disabled channels, or channels whose last element has finished. It leaves each triggered element time to complete before re-arming. Its bus model presents read data together with `bus_ready`. Request and force pulses last one cycle. The bus model switches between zero-wait and alternating-wait responses, and can stall completely, so that pending requests pile up.

// File: rtl/dmax_pkg.sv
package dmax_pkg;

  typedef enum logic [1:0] {
    AM_POSTINC = 2'd0,
    AM_FIXED   = 2'd1,
    AM_PERIPH  = 2'd2
  } amode_e;

  typedef enum logic [1:0] {
    OM_ONESHOT  = 2'd0,
    OM_REPEAT   = 2'd1,
    OM_PINGPONG = 2'd2
  } omode_e;

  typedef enum logic [1:0] {
    ES_IDLE  = 2'd0,
    ES_READ  = 2'd1,
    ES_WRITE = 2'd2
  } eng_state_e;

endpackage

// File: rtl/dmax_src_mux.sv
module dmax_src_mux #(
  parameter int NSRC = 16,
  parameter int OW   = 8
) (
  input  logic [7:0]         sel,
  input  logic [NSRC-1:0]    src_req,
  input  logic [NSRC*OW-1:0] src_off,
  input  logic               sw_kick,
  output logic               trig,
  output logic [OW-1:0]      trig_off
);

  // Codes at or above NSRC match no line; only the software kick remains.
  always_comb begin
    trig     = sw_kick;
    trig_off = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (sel == 8'(s)) begin
        trig     = sw_kick | src_req[s];
        trig_off = src_off[s*OW +: OW];
      end
    end
  end

endmodule

// File: rtl/dmax_arbiter.sv
module dmax_arbiter #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  oh
);

  // Lowest index wins: scan downward so the last hit is the smallest index.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
    for (int i = 0; i < N; i++) begin
      oh[i] = any && (idx == IW'(i));
    end
  end

endmodule

// File: rtl/dmax_channel.sv
module dmax_channel
  import dmax_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 10,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig,
  input  logic [OW-1:0] trig_off,
  input  logic          grant,
  input  logic          done,
  input  logic          cfg_byte,
  input  logic [1:0]    cfg_amode,
  input  logic [1:0]    cfg_omode,
  input  logic          cfg_half_en,
  input  logic [AW-1:0] cfg_ram_a,
  input  logic [AW-1:0] cfg_ram_b,
  input  logic [CW-1:0] cfg_len,
  output logic          en,
  output logic          pend,
  output logic [AW-1:0] ram_addr,
  output logic          irq_half,
  output logic          irq_full
);

  amode_e        am;
  omode_e        om;
  logic          en_q, en_n, pend_q, pend_n, pp_q, pp_n;
  logic [AW-1:0] ptr_q, ptr_n, step;
  logic [CW-1:0] idx_q, idx_n, half_idx;
  logic [CW:0]   len_p1;
  logic [OW-1:0] off_q, off_n;
  logic          irqh_q, irqh_n, irqf_q, irqf_n;
  logic          last, upd;

  always_comb begin
    am       = amode_e'(cfg_amode);
    om       = omode_e'(cfg_omode);
    last     = (idx_q == cfg_len);
    len_p1   = {1'b0, cfg_len} + (CW+1)'(1);
    half_idx = len_p1[CW:1];
    step     = cfg_byte ? AW'(1) : AW'(2);
    ram_addr = (am == AM_PERIPH) ? (ptr_q + AW'(off_q)) : ptr_q;
    upd      = arm | trig | grant | done;
  end

  always_comb begin
    en_n   = en_q;
    pend_n = pend_q;
    pp_n   = pp_q;
    ptr_n  = ptr_q;
    idx_n  = idx_q;
    off_n  = off_q;
    irqh_n = 1'b0;
    irqf_n = 1'b0;
    if (arm) begin
      en_n   = 1'b1;
      pend_n = 1'b0;
      pp_n   = 1'b0;
      ptr_n  = cfg_ram_a;
      idx_n  = '0;
      off_n  = '0;
    end else begin
      if (grant) pend_n = 1'b0;
      if (done) begin
        irqh_n = cfg_half_en && (idx_q == half_idx);
        if (last) begin
          irqf_n = 1'b1;
          idx_n  = '0;
          case (om)
            OM_REPEAT:   ptr_n = cfg_ram_a;
            OM_PINGPONG: begin
              pp_n  = ~pp_q;
              ptr_n = pp_q ? cfg_ram_a : cfg_ram_b;
            end
            default: begin
              en_n   = 1'b0;
              pend_n = 1'b0;
              ptr_n  = cfg_ram_a;
            end
          endcase
        end else begin
          idx_n = idx_q + CW'(1);
          if (am == AM_POSTINC) ptr_n = ptr_q + step;
        end
      end
      // Requests merge into a single pending flag; disabled channels drop them.
      if (trig && en_q && en_n) begin
        if (!pend_q || grant) off_n = trig_off;
        pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      pp_q   <= 1'b0;
      ptr_q  <= '0;
      idx_q  <= '0;
      off_q  <= '0;
      irqh_q <= 1'b0;
      irqf_q <= 1'b0;
    end else begin
      if (upd) begin
        en_q   <= en_n;
        pend_q <= pend_n;
        pp_q   <= pp_n;
        ptr_q  <= ptr_n;
        idx_q  <= idx_n;
        off_q  <= off_n;
      end
      irqh_q <= irqh_n;
      irqf_q <= irqf_n;
    end
  end

  assign en       = en_q;
  assign pend     = pend_q;
  assign irq_half = irqh_q;
  assign irq_full = irqf_q;

endmodule

// File: rtl/dmax_engine.sv
module dmax_engine
  import dmax_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = 2,
  parameter int AW  = 16,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pend,
  input  logic [NCH-1:0]    ch_dir,
  input  logic [NCH-1:0]    ch_byte,
  input  logic [NCH*AW-1:0] ram_addr,
  input  logic [NCH*AW-1:0] per_addr,
  output logic [NCH-1:0]    grant,
  output logic [NCH-1:0]    done,
  output logic              bus_valid,
  output logic              bus_write,
  output logic              bus_to_ram,
  output logic              bus_byte,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_ready,
  input  logic [DW-1:0]     bus_rdata
);

  eng_state_e    st_q, st_n;
  logic [IW-1:0] ch_q, arb_idx;
  logic [NCH-1:0] arb_oh;
  logic          arb_any;
  logic [AW-1:0] src_q, src_n, dst_q, dst_n, sel_ram, sel_per;
  logic          dir_q, dir_n, byte_q, byte_n;
  logic [DW-1:0] data_q, data_n;
  logic          start, capture;

  dmax_arbiter #(.N(NCH), .IW(IW)) u_arb (
    .req (pend),
    .any (arb_any),
    .idx (arb_idx),
    .oh  (arb_oh)
  );

  always_comb begin
    sel_ram = ram_addr[arb_idx*AW +: AW];
    sel_per = per_addr[arb_idx*AW +: AW];
    start   = (st_q == ES_IDLE) && arb_any;
    capture = (st_q == ES_READ) && bus_ready;
    grant   = (st_q == ES_IDLE) ? arb_oh : '0;
    for (int i = 0; i < NCH; i++) begin
      done[i] = (st_q == ES_WRITE) && bus_ready && (ch_q == IW'(i));
    end
  end

  always_comb begin
    st_n   = st_q;
    dir_n  = ch_dir[arb_idx];
    byte_n = ch_byte[arb_idx];
    src_n  = dir_n ? sel_ram : sel_per;
    dst_n  = dir_n ? sel_per : sel_ram;
    data_n = byte_q ? DW'(bus_rdata[7:0]) : bus_rdata;
    case (st_q)
      ES_IDLE:  if (arb_any)   st_n = ES_READ;
      ES_READ:  if (bus_ready) st_n = ES_WRITE;
      ES_WRITE: if (bus_ready) st_n = ES_IDLE;
      default:                 st_n = ES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ES_IDLE;
      ch_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      dir_q  <= 1'b0;
      byte_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q <= st_n;
      if (start) begin
        ch_q   <= arb_idx;
        src_q  <= src_n;
        dst_q  <= dst_n;
        dir_q  <= dir_n;
        byte_q <= byte_n;
      end
      if (capture) data_q <= data_n;
    end
  end

  always_comb begin
    bus_valid  = (st_q != ES_IDLE);
    bus_write  = (st_q == ES_WRITE);
    bus_addr   = bus_write ? dst_q : src_q;
    bus_to_ram = bus_write ? ~dir_q : dir_q;
    bus_byte   = byte_q;
    bus_wdata  = data_q;
  end

endmodule

// File: rtl/dmax_top.sv
module dmax_top
  import dmax_pkg::*;
#(
  parameter int NCH  = 4,   // 1 .. 15
  parameter int NSRC = 16,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int CW   = 10,
  parameter int OW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     ch_arm,
  input  logic [NCH-1:0]     cfg_dir,
  input  logic [NCH-1:0]     cfg_byte,
  input  logic [2*NCH-1:0]   cfg_amode,
  input  logic [2*NCH-1:0]   cfg_omode,
  input  logic [NCH-1:0]     cfg_half_en,
  input  logic [8*NCH-1:0]   cfg_srcsel,
  input  logic [AW*NCH-1:0]  cfg_ram_a,
  input  logic [AW*NCH-1:0]  cfg_ram_b,
  input  logic [AW*NCH-1:0]  cfg_per_addr,
  input  logic [CW*NCH-1:0]  cfg_len,
  input  logic [NCH-1:0]     sw_force,
  input  logic [NSRC-1:0]    src_req,
  input  logic [OW*NSRC-1:0] src_off,
  output logic               bus_valid,
  output logic               bus_write,
  output logic               bus_to_ram,
  output logic               bus_byte,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic               bus_ready,
  input  logic [DW-1:0]      bus_rdata,
  output logic [NCH-1:0]     ch_enabled,
  output logic [NCH-1:0]     irq_half,
  output logic [NCH-1:0]     irq_full
);

  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SELW = 8;

  logic [NCH-1:0]    ch_pend, eng_grant, eng_done;
  logic [NCH*AW-1:0] ch_ram_addr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          trig;
    logic [OW-1:0] toff;

    dmax_src_mux #(.NSRC(NSRC), .OW(OW)) u_mux (
      .sel      (cfg_srcsel[c*SELW +: SELW]),
      .src_req  (src_req),
      .src_off  (src_off),
      .sw_kick  (sw_force[c]),
      .trig     (trig),
      .trig_off (toff)
    );

    dmax_channel #(.AW(AW), .CW(CW), .OW(OW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (ch_arm[c]),
      .trig        (trig),
      .trig_off    (toff),
      .grant       (eng_grant[c]),
      .done        (eng_done[c]),
      .cfg_byte    (cfg_byte[c]),
      .cfg_amode   (cfg_amode[2*c +: 2]),
      .cfg_omode   (cfg_omode[2*c +: 2]),
      .cfg_half_en (cfg_half_en[c]),
      .cfg_ram_a   (cfg_ram_a[c*AW +: AW]),
      .cfg_ram_b   (cfg_ram_b[c*AW +: AW]),
      .cfg_len     (cfg_len[c*CW +: CW]),
      .en          (ch_enabled[c]),
      .pend        (ch_pend[c]),
      .ram_addr    (ch_ram_addr[c*AW +: AW]),
      .irq_half    (irq_half[c]),
      .irq_full    (irq_full[c])
    );
  end

  dmax_engine #(.NCH(NCH), .IW(IW), .AW(AW), .DW(DW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (ch_pend),
    .ch_dir     (cfg_dir),
    .ch_byte    (cfg_byte),
    .ram_addr   (ch_ram_addr),
    .per_addr   (cfg_per_addr),
    .grant      (eng_grant),
    .done       (eng_done),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_to_ram (bus_to_ram),
    .bus_byte   (bus_byte),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: rtl/dmax_chk.sv
module dmax_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [NCH-1:0]   grant,
  input logic [NCH-1:0]   en,
  input logic [NCH-1:0]   irq_full,
  input logic [NCH-1:0]   irq_half,
  input logic [2*NCH-1:0] omode
);

  a_r13_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
                                $stable(bus_write) && $stable(bus_wdata));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r12_grant_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~en) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_prop
    a_r8_oneshot_disables: assert property (@(posedge clk) disable iff (!rst_n)
      irq_full[i] && (omode[2*i +: 2] == 2'd0) |-> !en[i]);

    a_r8_full_after_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_full[i]) |-> $past(en[i]));

    a_r11_half_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_half[i] |=> !irq_half[i]);
  end

endmodule

bind dmax_top dmax_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .grant     (eng_grant),
  .en        (ch_enabled),
  .irq_full  (irq_full),
  .irq_half  (irq_half),
  .omode     (cfg_omode)
);

// File: tb/dmax_top_test.sv
module dmax_top_test;

  localparam int NCH = 4, NSRC = 16, AW = 16, DW = 16, CW = 10, OW = 8;

  logic clk, rst_n;
  logic [NCH-1:0]     ch_arm, cfg_dir, cfg_byte, cfg_half_en, sw_force;
  logic [2*NCH-1:0]   cfg_amode, cfg_omode;
  logic [8*NCH-1:0]   cfg_srcsel;
  logic [AW*NCH-1:0]  cfg_ram_a, cfg_ram_b, cfg_per_addr;
  logic [CW*NCH-1:0]  cfg_len;
  logic [NSRC-1:0]    src_req;
  logic [OW*NSRC-1:0] src_off;
  logic               bus_valid, bus_write, bus_to_ram, bus_byte, bus_ready;
  logic [AW-1:0]      bus_addr;
  logic [DW-1:0]      bus_wdata, bus_rdata;
  logic [NCH-1:0]     ch_enabled, irq_half, irq_full;

  dmax_top #(.NCH(NCH), .NSRC(NSRC), .AW(AW), .DW(DW), .CW(CW), .OW(OW)) uut (
    .clk(clk), .rst_n(rst_n), .ch_arm(ch_arm), .cfg_dir(cfg_dir), .cfg_byte(cfg_byte),
    .cfg_amode(cfg_amode), .cfg_omode(cfg_omode), .cfg_half_en(cfg_half_en),
    .cfg_srcsel(cfg_srcsel), .cfg_ram_a(cfg_ram_a), .cfg_ram_b(cfg_ram_b),
    .cfg_per_addr(cfg_per_addr), .cfg_len(cfg_len), .sw_force(sw_force),
    .src_req(src_req), .src_off(src_off), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_to_ram(bus_to_ram), .bus_byte(bus_byte), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .ch_enabled(ch_enabled), .irq_half(irq_half), .irq_full(irq_full)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int nchk = 0, nfail = 0, cyc = 0;
  logic finished = 1'b0;
  logic stall = 1'b0, slow = 1'b0;
  logic [7:0]  ram_m [0:255];
  logic [7:0]  rdseq = 8'd0;
  logic [15:0] lg_addr [0:63];
  logic [15:0] lg_data [0:63];
  logic        lg_ram  [0:63];
  logic        lg_byte [0:63];
  logic [15:0] rd_addr [0:63];
  logic        rd_ram  [0:63];
  int nwr = 0, nrd = 0;
  int nfull [0:NCH-1];
  int nhalf [0:NCH-1];
  int half_at [0:NCH-1];

  // Bus model and event logger, evaluated between clock edges.
  always @(negedge clk) begin
    logic [7:0] a;
    logic rdy;
    cyc++;
    for (int i = 0; i < NCH; i++) begin
      if (irq_full[i]) nfull[i]++;
      if (irq_half[i]) begin nhalf[i]++; half_at[i] = nwr; end
    end
    rdy = bus_valid && !stall && (!slow || cyc[0]);
    bus_ready = rdy;
    a = bus_addr[7:0];
    if (rdy) begin
      if (!bus_write) begin
        if (nrd < 64) begin rd_addr[nrd] = bus_addr; rd_ram[nrd] = bus_to_ram; end
        nrd++;
        if (bus_to_ram) bus_rdata = bus_byte ? {8'hEE, ram_m[a]} : {ram_m[a + 8'd1], ram_m[a]};
        else begin bus_rdata = {a, rdseq}; rdseq = rdseq + 8'd1; end
      end else begin
        if (nwr < 64) begin
          lg_addr[nwr] = bus_addr; lg_data[nwr] = bus_wdata;
          lg_ram[nwr] = bus_to_ram; lg_byte[nwr] = bus_byte;
        end
        nwr++;
        if (bus_to_ram) begin
          ram_m[a] = bus_wdata[7:0];
          if (!bus_byte) ram_m[a + 8'd1] = bus_wdata[15:8];
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int c, input bit dir, input bit byt, input int am, input int om,
                         input bit hen, input int sel, input int ra, input int rb,
                         input int pa, input int len);
    cfg_dir[c] = dir; cfg_byte[c] = byt; cfg_half_en[c] = hen;
    cfg_amode[2*c +: 2] = 2'(am); cfg_omode[2*c +: 2] = 2'(om);
    cfg_srcsel[8*c +: 8] = 8'(sel);
    cfg_ram_a[AW*c +: AW] = AW'(ra); cfg_ram_b[AW*c +: AW] = AW'(rb);
    cfg_per_addr[AW*c +: AW] = AW'(pa); cfg_len[CW*c +: CW] = CW'(len);
  endtask

  task automatic arm(input logic [NCH-1:0] m);
    @(posedge clk); #1 ch_arm = m;
    @(posedge clk); #1 ch_arm = '0;
  endtask

  task automatic kick(input logic [NCH-1:0] m);
    @(posedge clk); #1 sw_force = m;
    @(posedge clk); #1 sw_force = '0;
  endtask

  task automatic pulse_src(input int s, input int off);
    @(posedge clk); #1 src_req[s] = 1'b1; src_off[s*OW +: OW] = OW'(off);
    @(posedge clk); #1 src_req[s] = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int w0, r0, f0, h0;
    logic [7:0] s0;
    for (int i = 0; i < 256; i++) ram_m[i] = 8'h00;
    for (int i = 0; i < NCH; i++) begin nfull[i] = 0; nhalf[i] = 0; half_at[i] = 0; end
    bus_ready = 1'b0; bus_rdata = '0;
    ch_arm = '0; sw_force = '0; src_req = '0; src_off = '0;
    cfg_dir = '0; cfg_byte = '0; cfg_half_en = '0; cfg_amode = '0; cfg_omode = '0;
    cfg_srcsel = '1; cfg_ram_a = '0; cfg_ram_b = '0; cfg_per_addr = '0; cfg_len = '0;
    rst_n = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1: idle state after reset
    chk("R1 bus_valid", int'(bus_valid), 0);
    chk("R1 ch_enabled", int'(ch_enabled), 0);
    chk("R1 irq", int'({irq_full, irq_half}), 0);

    // Word, post-increment, one-shot, peripheral to RAM, source 5, N=4
    set_cfg(0, 0, 0, 0, 0, 1, 5, 'h10, 'h00, 'h40, 3);
    arm(4'b0001);
    s0 = rdseq; w0 = nwr; r0 = nrd; f0 = nfull[0]; h0 = nhalf[0];
    for (int k = 0; k < 4; k++) begin pulse_src(5, 0); settle(10); end
    for (int k = 0; k < 4; k++)
      chk("R4 R7 postinc word data", int'({ram_m[8'h11 + 8'(2*k)], ram_m[8'h10 + 8'(2*k)]}),
          int'({8'h40, 8'(s0 + 8'(k))}));
    chk("R2 read peripheral addr", int'(rd_addr[r0]), 'h40);
    chk("R2 read peripheral space", int'(rd_ram[r0]), 0);
    chk("R2 write RAM space", int'(lg_ram[w0]), 1);
    chk("R8 full irq count", nfull[0] - f0, 1);
    chk("R8 disabled after block", int'(ch_enabled[0]), 0);
    chk("R11 half irq count", nhalf[0] - h0, 1);
    chk("R11 half after element 2", half_at[0] - w0, 3);
    pulse_src(5, 0); settle(10);
    chk("R12 disabled request ignored", nwr - w0, 4);

    // Byte, fixed address, RAM to peripheral, force only, slow bus
    slow = 1'b1;
    ram_m[8'h30] = 8'h5A; ram_m[8'h31] = 8'h77;
    set_cfg(1, 1, 1, 1, 0, 0, 'hFF, 'h30, 'h00, 'h50, 2);
    arm(4'b0010);
    w0 = nwr; r0 = nrd;
    pulse_src(15, 0); settle(10);
    chk("R7 unselected code ignored", nwr - w0, 0);
    for (int k = 0; k < 3; k++) begin kick(4'b0010); settle(12); end
    chk("R13 writes under wait states", nwr - w0, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R6 byte zero-extend", int'(lg_data[w0+k]), 'h005A);
      chk("R6 bus_byte", int'(lg_byte[w0+k]), 1);
      chk("R2 write peripheral", int'({lg_ram[w0+k], lg_addr[w0+k]}), 'h0050);
      chk("R4 fixed RAM addr", int'({rd_ram[r0+k], rd_addr[r0+k]}), 'h10030);
    end
    chk("R8 one-shot byte disabled", int'(ch_enabled[1]), 0);
    slow = 1'b0;

    // Auto-repeat, N=2, three blocks
    set_cfg(2, 0, 0, 0, 1, 0, 9, 'h60, 'h00, 'h44, 1);
    arm(4'b0100);
    w0 = nwr; f0 = nfull[2];
    for (int k = 0; k < 6; k++) begin pulse_src(9, 0); settle(10); end
    for (int k = 0; k < 6; k++)
      chk("R9 repeat address", int'(lg_addr[w0+k]), 'h60 + 2*(k%2));
    chk("R9 full irq count", nfull[2] - f0, 3);
    chk("R9 stays enabled", int'(ch_enabled[2]), 1);

    // Ping-pong, N=2, three blocks
    set_cfg(3, 0, 0, 0, 2, 0, 10, 'h80, 'hA0, 'h46, 1);
    arm(4'b1000);
    w0 = nwr; f0 = nfull[3];
    for (int k = 0; k < 6; k++) begin pulse_src(10, 0); settle(10); end
    for (int k = 0; k < 6; k++)
      chk("R10 ping-pong address", int'(lg_addr[w0+k]),
          (((k/2)%2) == 1 ? 'hA0 : 'h80) + 2*(k%2));
    chk("R10 full irq count", nfull[3] - f0, 3);
    chk("R10 stays enabled", int'(ch_enabled[3]), 1);

    // Peripheral-indirect addressing
    set_cfg(0, 0, 0, 2, 0, 0, 7, 'h70, 'h00, 'h48, 0);
    arm(4'b0001);
    w0 = nwr;
    pulse_src(7, 'h06); settle(10);
    chk("R5 indirect RAM addr", int'(lg_addr[w0]), 'h76);

    // Priority and merging under a stalled bus
    set_cfg(0, 0, 0, 0, 0, 0, 'hFF, 'hC0, 'h00, 'h4A, 1);
    set_cfg(1, 0, 0, 0, 0, 0, 'hFF, 'hD0, 'h00, 'h4C, 1);
    arm(4'b0011);
    w0 = nwr;
    stall = 1'b1;
    kick(4'b0001);
    settle(2);
    kick(4'b0010); kick(4'b0010); kick(4'b0010); kick(4'b0001);
    settle(2);
    stall = 1'b0;
    settle(30);
    chk("R12 merged element count", nwr - w0, 3);
    chk("R3 first ch0", int'(lg_addr[w0]), 'hC0);
    chk("R3 ch0 beats pending ch1", int'(lg_addr[w0+1]), 'hC2);
    chk("R3 ch1 last", int'(lg_addr[w0+2]), 'hD0);
    chk("R12 ch1 still enabled", int'(ch_enabled[1:0]), 2);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule